// File: doc/BRIEF.md
# DMA Line-Splitting Request Sequencer

This block takes one DMA read or write at a time from a requester and carries it out as a chain of cache-line transactions toward memory. A request gives a start address, a byte count and, for writes, the payload. The block sends one line transaction to a downstream line port and then waits for that line's read data or write acknowledge before it sends the next one. On reads it collects the returned bytes into a gather buffer. When the last byte is done it raises a single response, and it can accept a new request in that same cycle.

Only the first transaction can start partway into a line. Its length is cut at the line boundary, and every later transaction starts on a line boundary. A request offered while the block is busy is not accepted. The refusal is remembered, and the requester gets a one-cycle retry pulse when the running request completes. A drain input makes the block report when it holds no request.

Top module: `dma_line_seq`

## Requirements
- R1: `req_accept` equals `req_valid` AND not busy. A request offered while busy is not taken, and the running request's transactions are not disturbed.
- R2: The first transaction of a request has address equal to the start address. Its length is the request length when (start mod line size) + length fits in the line, and otherwise it is line size minus (start mod line size).
- R3: Each later transaction has address start + bytes completed, which is line-aligned. Its length is the smaller of the remaining bytes and the line size.
- R4: `ln_store` is 1 for writes and 0 for reads. For a write, byte lane (offset + i) of `ln_wdata` carries request byte (bytes completed + i), and `ln_be` is set exactly on lanes offset to offset + length - 1. Request byte k sits at `req_wdata[8k+7:8k]`.
- R5: On a read return, `ln_rdata` lanes offset to offset + length - 1 are stored at gather positions bytes completed onward. The offset is the start's line offset for the first transaction and 0 for later ones. Response byte k is `rsp_rdata[8k+7:8k]`, and bytes at or beyond the length read as 0.
- R6: `ln_valid` is high only while busy with no transaction outstanding. Its address and length hold while `ln_ready` is low. After a handshake, no new transaction is issued until the matching `ln_rvalid` (read) or `ln_wack` (write) arrives.
- R7: On the final return, busy clears at that clock edge, so a request offered in the next cycle is accepted.
- R8: If any request was refused during the busy period (including in the final return cycle), `retry` is high for exactly the one cycle after the final return. Otherwise it stays low.
- R9: `rsp_valid` is high for exactly the one cycle after the final return, and only when the request was taken with `req_need_rsp` = 1.
- R10: `drained` is high when `drain_req` was high on the previous clock and no request is held.
- R11: After reset, `ln_valid`, `rsp_valid`, `retry` and `drained` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 = write, 0 = read |
| req_need_rsp | input | 1 | Requester expects a response |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Byte count, 1 to MAX_BYTES |
| req_wdata | input | MAX_BYTES*8 | Write payload, byte k at bits 8k+7:8k |
| req_accept | output | 1 | Request taken this cycle |
| retry | output | 1 | One-cycle retry indication |
| rsp_valid | output | 1 | One-cycle completion response |
| rsp_rdata | output | MAX_BYTES*8 | Gathered read bytes |
| ln_valid | output | 1 | Line transaction offered |
| ln_ready | input | 1 | Downstream takes the transaction |
| ln_addr | output | ADDR_W | Transaction byte address |
| ln_len | output | LLEN_W | Transaction byte count |
| ln_store | output | 1 | 1 = store, 0 = load |
| ln_wdata | output | LINE_BYTES*8 | Store data placed in line lanes |
| ln_be | output | LINE_BYTES | Store byte enables |
| ln_rvalid | input | 1 | Load data return |
| ln_rdata | input | LINE_BYTES*8 | Whole line of load data |
| ln_wack | input | 1 | Store acknowledge |
| drain_req | input | 1 | Drain request |
| drained | output | 1 | Draining and empty |

## Verification
The hardest situation to reach is a refusal that lands on the same clock as the final line return. The retry must then still fire even though the pending flag is cleared on that same edge. Right after it, a request must be accepted in the cycle in which the response appears. The bench gets there by keeping a second request asserted through the whole life of the first, which refuses it on every busy cycle including the completion cycle. It varies the downstream ready pattern and the return latency, and runs unaligned reads and writes that span one, two and three lines.

// File: rtl/dma_line_seq_pkg.sv
package dma_line_seq_pkg;
    typedef enum logic {
        PH_ISSUE = 1'b0,
        PH_WAIT  = 1'b1
    } seq_phase_e;
endpackage

// File: rtl/dma_seg_calc.sv
module dma_seg_calc #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int MAX_BYTES  = 128,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LEN_W     = $clog2(MAX_BYTES + 1),
    localparam int LLEN_W    = $clog2(LINE_BYTES + 1)
) (
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  total_len,
    input  logic [LEN_W-1:0]  done_len,
    output logic [ADDR_W-1:0] seg_addr,
    output logic [OFF_W-1:0]  seg_off,
    output logic [LLEN_W-1:0] seg_len
);
    logic [LEN_W-1:0]  remain;
    logic [LLEN_W-1:0] room;

    // one formula covers both the unaligned head (R2) and aligned tails (R3)
    assign seg_addr = start_addr + ADDR_W'(done_len);
    assign seg_off  = seg_addr[OFF_W-1:0];
    assign remain   = total_len - done_len;
    assign room     = LLEN_W'(LINE_BYTES) - LLEN_W'(seg_off);

    always_comb begin
        if (remain < LEN_W'(room)) seg_len = LLEN_W'(remain);
        else                       seg_len = room;
    end
endmodule

// File: rtl/dma_lane_pack.sv
module dma_lane_pack #(
    parameter int LINE_BYTES = 64,
    parameter int MAX_BYTES  = 128,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LEN_W     = $clog2(MAX_BYTES + 1),
    localparam int LLEN_W    = $clog2(LINE_BYTES + 1)
) (
    input  logic [MAX_BYTES*8-1:0]  src_buf,
    input  logic [LEN_W-1:0]        done_len,
    input  logic [OFF_W-1:0]        seg_off,
    input  logic [LLEN_W-1:0]       seg_len,
    output logic [LINE_BYTES*8-1:0] lane_data,
    output logic [LINE_BYTES-1:0]   lane_be
);
    for (genvar i = 0; i < LINE_BYTES; i++) begin : g_lane
        logic [LEN_W-1:0] src_idx;
        assign lane_be[i] = (LLEN_W'(i) >= {1'b0, seg_off}) &&
                            (LLEN_W'(i) < {1'b0, seg_off} + seg_len);
        assign src_idx = done_len + LEN_W'(i) - LEN_W'(seg_off);
        assign lane_data[i*8 +: 8] = lane_be[i] ? src_buf[{src_idx, 3'b000} +: 8] : 8'h00;
    end
endmodule

// File: rtl/dma_lane_gather.sv
module dma_lane_gather #(
    parameter int LINE_BYTES = 64,
    parameter int MAX_BYTES  = 128,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LEN_W     = $clog2(MAX_BYTES + 1),
    localparam int LLEN_W    = $clog2(LINE_BYTES + 1)
) (
    input  logic [MAX_BYTES*8-1:0]  old_buf,
    input  logic [LINE_BYTES*8-1:0] line_data,
    input  logic [LEN_W-1:0]        done_len,
    input  logic [OFF_W-1:0]        seg_off,
    input  logic [LLEN_W-1:0]       seg_len,
    output logic [MAX_BYTES*8-1:0]  new_buf
);
    for (genvar j = 0; j < MAX_BYTES; j++) begin : g_slot
        logic             take;
        logic [OFF_W-1:0] lane_idx;
        assign take = (LEN_W'(j) >= done_len) &&
                      ({1'b0, LEN_W'(j)} < {1'b0, done_len} + (LEN_W+1)'(seg_len));
        assign lane_idx = OFF_W'(LEN_W'(j) - done_len) + seg_off;
        assign new_buf[j*8 +: 8] = take ? line_data[{lane_idx, 3'b000} +: 8]
                                        : old_buf[j*8 +: 8];
    end
endmodule

// File: rtl/dma_line_seq.sv
module dma_line_seq
    import dma_line_seq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int MAX_BYTES  = 128,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LEN_W     = $clog2(MAX_BYTES + 1),
    localparam int LLEN_W    = $clog2(LINE_BYTES + 1),
    localparam int LINE_W    = LINE_BYTES * 8,
    localparam int BUF_W     = MAX_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_need_rsp,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [BUF_W-1:0]  req_wdata,
    output logic              req_accept,
    output logic              retry,
    output logic              rsp_valid,
    output logic [BUF_W-1:0]  rsp_rdata,
    output logic              ln_valid,
    input  logic              ln_ready,
    output logic [ADDR_W-1:0] ln_addr,
    output logic [LLEN_W-1:0] ln_len,
    output logic              ln_store,
    output logic [LINE_W-1:0] ln_wdata,
    output logic [LINE_BYTES-1:0] ln_be,
    input  logic              ln_rvalid,
    input  logic [LINE_W-1:0] ln_rdata,
    input  logic              ln_wack,
    input  logic              drain_req,
    output logic              drained
);
    typedef struct packed {
        logic              busy;
        seq_phase_e        phase;
        logic              write;
        logic              need_rsp;
        logic [ADDR_W-1:0] start;
        logic [LEN_W-1:0]  total;
        logic [LEN_W-1:0]  done;
        logic [LEN_W-1:0]  issued;
        logic [BUF_W-1:0]  data_buf;
        logic              retry_pend;
        logic              retry_pulse;
        logic              rsp_pulse;
        logic              draining;
    } seq_state_t;

    seq_state_t state_d, state_q;

    logic [ADDR_W-1:0] seg_addr;
    logic [OFF_W-1:0]  seg_off;
    logic [LLEN_W-1:0] seg_len;
    logic [BUF_W-1:0]  gathered;
    logic              first_seg;

    dma_seg_calc #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .MAX_BYTES(MAX_BYTES)) seg_i (
        .start_addr (state_q.start),
        .total_len  (state_q.total),
        .done_len   (state_q.done),
        .seg_addr   (seg_addr),
        .seg_off    (seg_off),
        .seg_len    (seg_len)
    );

    dma_lane_pack #(.LINE_BYTES(LINE_BYTES), .MAX_BYTES(MAX_BYTES)) pack_i (
        .src_buf   (state_q.data_buf),
        .done_len  (state_q.done),
        .seg_off   (seg_off),
        .seg_len   (seg_len),
        .lane_data (ln_wdata),
        .lane_be   (ln_be)
    );

    dma_lane_gather #(.LINE_BYTES(LINE_BYTES), .MAX_BYTES(MAX_BYTES)) gather_i (
        .old_buf   (state_q.data_buf),
        .line_data (ln_rdata),
        .done_len  (state_q.done),
        .seg_off   (seg_off),
        .seg_len   (seg_len),
        .new_buf   (gathered)
    );

    logic take_req, refuse_req, line_ret, finishing;

    always_comb begin
        take_req   = req_valid && !state_q.busy;                       // R1
        refuse_req = req_valid && state_q.busy;
        line_ret   = state_q.busy && (state_q.phase == PH_WAIT) &&
                     (state_q.write ? ln_wack : ln_rvalid);            // R6
        finishing  = line_ret && (state_q.issued == state_q.total);

        state_d             = state_q;
        state_d.retry_pulse = 1'b0;
        state_d.rsp_pulse   = 1'b0;
        state_d.draining    = drain_req;                               // R10

        if (line_ret) begin
            if (!state_q.write) state_d.data_buf = gathered;           // R5
            state_d.done = state_q.issued;
            if (finishing) begin
                state_d.busy        = 1'b0;                            // R7
                state_d.rsp_pulse   = state_q.need_rsp;                // R9
                state_d.retry_pulse = state_q.retry_pend | refuse_req; // R8
                state_d.retry_pend  = 1'b0;
            end else begin
                state_d.phase = PH_ISSUE;
            end
        end else if (state_q.busy && (state_q.phase == PH_ISSUE) && ln_ready) begin
            state_d.issued = state_q.done + LEN_W'(seg_len);
            state_d.phase  = PH_WAIT;
        end

        if (refuse_req && !finishing) state_d.retry_pend = 1'b1;

        if (take_req) begin
            state_d.busy     = 1'b1;
            state_d.phase    = PH_ISSUE;
            state_d.write    = req_write;
            state_d.need_rsp = req_need_rsp;
            state_d.start    = req_addr;
            state_d.total    = req_len;
            state_d.done     = '0;
            state_d.issued   = '0;
            state_d.data_buf = req_write ? req_wdata : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign first_seg  = (state_q.done == '0);
    assign req_accept = take_req;
    assign ln_valid   = state_q.busy && (state_q.phase == PH_ISSUE);
    assign ln_addr    = seg_addr;
    assign ln_len     = seg_len;
    assign ln_store   = state_q.write;                                 // R4
    assign rsp_valid  = state_q.rsp_pulse;
    assign rsp_rdata  = state_q.data_buf;
    assign retry      = state_q.retry_pulse;
    assign drained    = state_q.draining && !state_q.busy;
endmodule

// File: rtl/dma_line_seq_chk.sv
module dma_line_seq_chk #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LLEN_W    = $clog2(LINE_BYTES + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_accept,
    input logic              retry,
    input logic              rsp_valid,
    input logic              ln_valid,
    input logic              ln_ready,
    input logic [ADDR_W-1:0] ln_addr,
    input logic [LLEN_W-1:0] ln_len,
    input logic [LINE_BYTES-1:0] ln_be,
    input logic              ln_store,
    input logic              first_seg,
    input logic              drained
);
    AST_NO_ACCEPT_WHILE_ISSUING: assert property (@(posedge clk) disable iff (!rst_n)
        ln_valid |-> !req_accept);                                              // R1
    AST_SEG_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        ln_valid |-> ((LLEN_W + 1)'(ln_addr[OFF_W-1:0]) + (LLEN_W + 1)'(ln_len) <= (LLEN_W + 1)'(LINE_BYTES)) && (ln_len != '0)); // R2
    AST_TAIL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (ln_valid && !first_seg) |-> (ln_addr[OFF_W-1:0] == '0));              // R3
    AST_BE_MATCH_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ln_valid && ln_store) |-> ($countones(ln_be) == int'(ln_len)));       // R4
    AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (ln_valid && !ln_ready) |=> (ln_valid && $stable(ln_addr) && $stable(ln_len))); // R6
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        (ln_valid && ln_ready) |=> !ln_valid);                                  // R6
    AST_RETRY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        retry |=> !retry);                                                      // R8
    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);                                              // R9
    AST_DRAINED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        drained |-> !ln_valid);                                                 // R10
endmodule

bind dma_line_seq dma_line_seq_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_accept (req_accept),
    .retry      (retry),
    .rsp_valid  (rsp_valid),
    .ln_valid   (ln_valid),
    .ln_ready   (ln_ready),
    .ln_addr    (ln_addr),
    .ln_len     (ln_len),
    .ln_be      (ln_be),
    .ln_store   (ln_store),
    .first_seg  (first_seg),
    .drained    (drained)
);

// File: tb/dma_line_seq_tb_top.sv
module dma_line_seq_tb_top;
    localparam int AW = 32, LB = 64, MB = 128;
    localparam int LEN_W = $clog2(MB + 1), LLEN_W = $clog2(LB + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0, req_write = 0, req_need_rsp = 0;
    logic [AW-1:0] req_addr = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic [MB*8-1:0] req_wdata = '0;
    logic req_accept, retry, rsp_valid, ln_valid, ln_store, drained;
    logic [MB*8-1:0] rsp_rdata;
    logic ln_ready = 0, ln_rvalid = 0, ln_wack = 0, drain_req = 0;
    logic [AW-1:0] ln_addr;
    logic [LLEN_W-1:0] ln_len;
    logic [LB*8-1:0] ln_wdata, ln_rdata = '0;
    logic [LB-1:0] ln_be;

    always #4 clk = ~clk;

    dma_line_seq dut_i (.*);

    int checks = 0, errors = 0, cyc = 0;
    // reference model state
    int m_busy = 0, m_wait = 0, m_write = 0, m_needs = 0, m_start = 0, m_len = 0;
    int m_done = 0, m_issued = 0, m_pend = 0, m_drain = 0, m_fin = 0, exp_rsp = 0, exp_retry = 0;
    logic [7:0] m_wbuf [MB];
    logic [7:0] m_rbuf [MB];
    // stimulus staging and previous-cycle observations
    int nx_valid = 0, nx_write = 0, nx_needs = 0, nx_addr = 0, nx_len = 0, nx_drain = 0, nx_seed = 0;
    int p_accept = 0, p_refuse = 0, p_hs = 0, p_ret = 0, p_drain = 0;
    int p_write = 0, p_needs = 0, p_addr = 0, p_len = 0;
    logic [MB*8-1:0] p_wdata = '0;
    int rc_cnt = -1, rc_addr = 0, ready_mode = 0, in_reset = 1;

    function automatic int mem_byte(int a);
        return (a * 13 + 7) & 255;
    endfunction

    function automatic int seg_len_f();
        int rem = m_len - m_done;
        int room = LB - ((m_start + m_done) % LB);
        return (rem < room) ? rem : room;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s cycle %0d actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        if (!in_reset) begin
            exp_rsp = 0; exp_retry = 0; m_fin = 0;
            if (p_ret != 0 && m_busy != 0 && m_wait != 0) begin
                if (m_write == 0)
                    for (int k = 0; k < m_issued - m_done; k++)
                        m_rbuf[m_done + k] = 8'(mem_byte(m_start + m_done + k));
                m_done = m_issued;
                if (m_done == m_len) begin
                    m_busy = 0; m_fin = 1; exp_rsp = m_needs;
                    exp_retry = (m_pend != 0 || p_refuse != 0) ? 1 : 0; m_pend = 0;
                end else m_wait = 0;
            end else if (p_hs != 0) begin
                m_issued = m_done + seg_len_f(); m_wait = 1;
            end
            if (p_refuse != 0 && m_fin == 0) m_pend = 1;
            if (p_accept != 0) begin
                m_busy = 1; m_wait = 0; m_write = p_write; m_needs = p_needs;
                m_start = p_addr; m_len = p_len; m_done = 0; m_issued = 0;
                for (int k = 0; k < MB; k++) begin
                    m_rbuf[k] = 8'h00; m_wbuf[k] = p_wdata[k*8 +: 8];
                end
            end
            m_drain = p_drain;
        end
        // drive inputs
        req_valid = 1'(nx_valid); req_write = 1'(nx_write); req_need_rsp = 1'(nx_needs);
        req_addr = AW'(nx_addr); req_len = LEN_W'(nx_len); drain_req = 1'(nx_drain);
        for (int k = 0; k < MB; k++) req_wdata[k*8 +: 8] = 8'((k * 5 + nx_seed) & 255);
        ln_rvalid = 0; ln_wack = 0;
        if (rc_cnt == 0) begin
            if (m_write != 0) ln_wack = 1;
            else begin
                ln_rvalid = 1;
                for (int i = 0; i < LB; i++) ln_rdata[i*8 +: 8] = 8'(mem_byte((rc_addr & ~(LB - 1)) + i));
            end
            rc_cnt = -1;
        end else if (rc_cnt > 0) rc_cnt--;
        ln_ready = (ready_mode == 0) ? 1'b1 : 1'((cyc % 3) != 0);
        cyc++;
        #1;
        if (!in_reset) begin
            chk("R1 accept", int'(req_accept), (nx_valid != 0 && m_busy == 0) ? 1 : 0);
            if (m_fin != 0 && nx_valid != 0) chk("R7 accept after completion", int'(req_accept), 1);
            chk("R6 ln_valid", int'(ln_valid), (m_busy != 0 && m_wait == 0) ? 1 : 0);
            if (ln_valid) begin
                int sl = seg_len_f();
                int off = (m_start + m_done) % LB;
                if (m_done == 0) begin
                    chk("R2 first addr", int'(ln_addr), m_start);
                    chk("R2 first len", int'(ln_len), sl);
                end else begin
                    chk("R3 next addr", int'(ln_addr), m_start + m_done);
                    chk("R3 next len", int'(ln_len), sl);
                end
                chk("R4 store type", int'(ln_store), m_write);
                if (m_write != 0)
                    for (int i = 0; i < LB; i++) begin
                        int en = (i >= off && i < off + sl) ? 1 : 0;
                        chk("R4 byte enable", int'(ln_be[i]), en);
                        if (en != 0) chk("R4 lane data", int'(ln_wdata[i*8 +: 8]), int'(m_wbuf[m_done + i - off]));
                    end
            end
            chk("R9 rsp_valid", int'(rsp_valid), exp_rsp);
            if (rsp_valid && m_write == 0)
                for (int k = 0; k < MB; k++) chk("R5 gathered byte", int'(rsp_rdata[k*8 +: 8]), int'(m_rbuf[k]));
            chk("R8 retry", int'(retry), exp_retry);
            chk("R10 drained", int'(drained), (m_drain != 0 && m_busy == 0) ? 1 : 0);
        end
        // record what the next edge will see
        p_accept = (req_valid && req_accept) ? 1 : 0;
        p_refuse = (req_valid && !req_accept) ? 1 : 0;
        p_hs = (ln_valid && ln_ready) ? 1 : 0;
        if (p_hs != 0) begin rc_cnt = cyc % 4; rc_addr = int'(ln_addr); end
        p_ret = (ln_rvalid || ln_wack) ? 1 : 0;
        p_drain = nx_drain; p_write = nx_write; p_needs = nx_needs;
        p_addr = nx_addr; p_len = nx_len; p_wdata = req_wdata;
    endtask

    task automatic launch(int addr, int len, int wr, int needs, int seed);
        int guard = 0;
        nx_valid = 1; nx_addr = addr; nx_len = len; nx_write = wr; nx_needs = needs; nx_seed = seed;
        do begin step(); guard++; end while (p_accept == 0 && guard < 2000);
    endtask

    task automatic settle();
        int guard = 0;
        nx_valid = 0;
        do begin step(); guard++; end while (m_busy != 0 && guard < 2000);
        step(); step();
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        in_reset = 0;
        step();
        // R11 reset state
        chk("R11 ln_valid", int'(ln_valid), 0);
        chk("R11 rsp_valid", int'(rsp_valid), 0);
        chk("R11 retry", int'(retry), 0);
        chk("R11 drained", int'(drained), 0);

        launch(32'h1005, 10, 0, 1, 0); settle();           // R2 read within one line
        launch(32'h203C, 10, 0, 1, 0); settle();           // R3 read over a boundary
        ready_mode = 1;
        launch(32'h3005, 128, 1, 1, 17); settle();         // R4 write over three lines
        launch(32'h4000, 64, 0, 1, 0); settle();           // aligned full line read
        launch(32'h503F, 1, 0, 1, 0); settle();            // last byte of a line
        launch(32'h6021, 100, 0, 1, 0); settle();          // R5 read over three lines
        launch(32'h7010, 40, 1, 0, 3); settle();           // R9 write without response
        // R8/R7: second request held while the first runs
        launch(32'h8030, 90, 0, 1, 0);
        launch(32'h9002, 20, 1, 1, 9); settle();
        ready_mode = 0;
        launch(32'hA001, 70, 1, 1, 4);
        launch(32'hB003, 5, 0, 1, 0); settle();
        // R10 drain during and after a request
        nx_drain = 1;
        launch(32'hC00F, 60, 0, 1, 0); settle();
        nx_drain = 0; step(); step();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule